// File: doc/BRIEF.md
# Sampling Converter Serial Port Controller

This block is the digital control and serial interface of a 12-bit sampling converter. A single convert input controls the block. A rising edge starts a conversion of fixed length, counted in system-clock cycles. If the convert input is still high when the count ends, the block sleeps. A falling edge ends sleep, opens the serial output and starts a transfer. The conversion value itself is a stand-in word that arrives on a port, because the analog front end is not part of this block.

During a transfer the result leaves the block most significant bit first. Each new bit appears after a falling shift-clock edge, so the receiver can capture it on the rising edge. At the same time the block takes a 2-bit input-selection word from the serial input on the first two rising edges. That word steers the input pairing of the next conversion. The shift clock, the convert input and the serial input are all asynchronous to the system clock. Each passes through a two-flop synchronizer followed by an edge detector.

Top module: `adc_serial_port`

## Requirements
- R1: After reset the block is asleep, `sdo_oe_o` is 0, `err_o` is 0 and `mux_cfg_o` is 2'b10 (single-ended, channel 0).
- R2: A rising edge on `conv_i` starts a conversion, and `busy_o` stays high for exactly `CONV_CYCLES` system-clock cycles.
- R3: If `conv_i` is high when a conversion completes, `sleep_o` goes high. While `conv_i` is high, `sdo_oe_o` is 0 (the output is high-impedance).
- R4: A falling edge on `conv_i` sets `sdo_oe_o` to 1 and places result bit 11 on `sdo_o`. Each later falling `sck_i` edge moves to the next lower bit.
- R5: After all 12 result bits have been sent, each further falling `sck_i` edge while `conv_i` is low leaves `sdo_o` at 0.
- R6: The first `sdi_i` bit after `conv_i` falls is taken as the single-ended flag, and the second as the odd/sign bit. Both are sampled on rising `sck_i` edges while the result is still being shifted out. Any further `sdi_i` bits in the same transfer are ignored.
- R7: The captured word takes effect at the next conversion start and is shown on `mux_cfg_o` as {single, odd}. The pairings are: 2'b10 = CH0 against ground, 2'b11 = CH1 against ground, 2'b00 = CH0 positive and CH1 negative, 2'b01 = CH1 positive and CH0 negative.
- R8: A falling `conv_i` edge before the conversion completes sets `err_o`, and the transfer presents the previous result. `err_o` clears at the next conversion start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_i | input | 1 | Convert control, asynchronous |
| sck_i | input | 1 | Serial shift clock, asynchronous |
| sdi_i | input | 1 | Serial configuration input |
| sample_data_i | input | 12 | Stand-in conversion value, taken when the conversion completes |
| sdo_o | output | 1 | Serial result data |
| sdo_oe_o | output | 1 | Output enable for sdo_o; 0 means high-impedance |
| busy_o | output | 1 | Conversion in progress |
| sleep_o | output | 1 | Sleep state |
| err_o | output | 1 | Early-release error flag |
| mux_cfg_o | output | 2 | Input pairing applied to the current or most recent conversion |

## Verification
Some behaviours are checked by the embedded properties on every cycle:
- the conversion counter stays within its bound;
- the block enters sleep when `conv_i` is still high at completion;
- an early release raises the error flag;
- the MSB appears on load;
- the output is zero once twelve bits have gone out;
- the pending configuration is frozen after two captures;
- the applied configuration holds during a conversion.

Other behaviours can only be shown by the bench scenarios, driving real waveforms through the synchronizers:
- the exact busy length;
- the complete bit streams for several data patterns;
- the effect of a captured word on the following conversion and never the current one;
- the presentation of the older result after an early release.

// File: rtl/adc_serial_port_pkg.sv
package adc_serial_port_pkg;

  typedef enum logic [1:0] {
    ST_SLEEP   = 2'd0,
    ST_CONVERT = 2'd1,
    ST_XFER    = 2'd2
  } ctrl_state_e;

  typedef struct packed {
    logic single;
    logic odd;
  } mux_cfg_t;

  localparam mux_cfg_t CFG_RESET = '{single: 1'b1, odd: 1'b0};
  localparam int CFG_W = 2;

endpackage

// File: rtl/adc_sync_edge.sv
module adc_sync_edge #(
  parameter int  STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              prev_q;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], async_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= {STAGES{RST_VAL}};
      prev_q <= RST_VAL;
    end else begin
      sync_q <= sync_d;
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign level_o = sync_q[STAGES-1];
  assign rise_o  = sync_q[STAGES-1] & ~prev_q;
  assign fall_o  = ~sync_q[STAGES-1] & prev_q;

endmodule

// File: rtl/adc_conv_ctrl.sv
module adc_conv_ctrl
  import adc_serial_port_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int CONV_CYCLES = 400
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_lvl,
  input  logic              conv_rise,
  input  logic              conv_fall,
  input  logic [DATA_W-1:0] sample_data_i,
  input  mux_cfg_t          pend_cfg,
  output ctrl_state_e       state_o,
  output logic              load_o,
  output logic [DATA_W-1:0] load_data_o,
  output mux_cfg_t          applied_cfg_o,
  output logic              err_o
);

  localparam int CNT_W = $clog2(CONV_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CONV_CYCLES - 1);

  ctrl_state_e       state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] res_q, res_d;
  mux_cfg_t          cfg_q, cfg_d;
  logic              err_q, err_d;
  logic              done;
  logic              start;

  assign done  = (state_q == ST_CONVERT) && (cnt_q == '0);
  assign start = conv_rise && (state_q != ST_CONVERT);

  // next-state logic
  always_comb begin
    state_d     = state_q;
    cnt_d       = cnt_q;
    res_d       = res_q;
    cfg_d       = cfg_q;
    err_d       = err_q;
    load_o      = 1'b0;
    load_data_o = done ? sample_data_i : res_q;
    if (start) begin
      state_d = ST_CONVERT;
      cnt_d   = CNT_LAST;
      cfg_d   = pend_cfg;
      err_d   = 1'b0;
    end else begin
      case (state_q)
        ST_SLEEP: begin
          if (conv_fall) begin
            state_d = ST_XFER;
            load_o  = 1'b1;
          end
        end
        ST_CONVERT: begin
          if (done) begin
            res_d = sample_data_i;
            if (conv_lvl && !conv_fall) begin
              state_d = ST_SLEEP;
            end else begin
              state_d = ST_XFER;
              load_o  = 1'b1;
            end
          end else if (conv_fall) begin
            err_d   = 1'b1;
            state_d = ST_XFER;
            load_o  = 1'b1;
          end else begin
            cnt_d = cnt_q - 1'b1;
          end
        end
        default: begin
          state_d = state_q;
        end
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_SLEEP;
      cnt_q   <= '0;
      res_q   <= '0;
      cfg_q   <= CFG_RESET;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      res_q   <= res_d;
      cfg_q   <= cfg_d;
      err_q   <= err_d;
    end
  end

  assign state_o       = state_q;
  assign applied_cfg_o = cfg_q;
  assign err_o         = err_q;

  a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CONVERT) |-> (cnt_q < CNT_W'(CONV_CYCLES)));

  a_r3_sleep_when_high: assert property (@(posedge clk) disable iff (!rst_n)
    (done && conv_lvl && !conv_fall) |=> (state_q == ST_SLEEP));

  a_r8_early_err: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_CONVERT) && (cnt_q != '0) && conv_fall) |=> err_q);

  a_r7_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CONVERT) |=> $stable(cfg_q));

endmodule

// File: rtl/adc_shift_port.sv
module adc_shift_port
  import adc_serial_port_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              xfer_en,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              sdi_lvl,
  output logic              sdo,
  output mux_cfg_t          pend_cfg
);

  localparam int SENT_W = $clog2(DATA_W + 1);
  localparam int SDI_W  = $clog2(CFG_W + 1);
  localparam logic [SENT_W-1:0] SENT_MAX = SENT_W'(DATA_W);
  localparam logic [SDI_W-1:0]  SDI_MAX  = SDI_W'(CFG_W);

  logic [DATA_W-1:0] shreg_q, shreg_d;
  logic [SENT_W-1:0] sent_q, sent_d;
  logic [SDI_W-1:0]  sdi_cnt_q, sdi_cnt_d;
  mux_cfg_t          pend_q, pend_d;

  always_comb begin
    shreg_d   = shreg_q;
    sent_d    = sent_q;
    sdi_cnt_d = sdi_cnt_q;
    pend_d    = pend_q;
    if (load) begin
      shreg_d   = load_data;
      sent_d    = '0;
      sdi_cnt_d = '0;
    end else if (xfer_en) begin
      if (sck_fall) begin
        shreg_d = {shreg_q[DATA_W-2:0], 1'b0};
        if (sent_q != SENT_MAX) begin
          sent_d = sent_q + 1'b1;
        end
      end
      if (sck_rise && (sdi_cnt_q != SDI_MAX)) begin
        if (sdi_cnt_q == '0) begin
          pend_d.single = sdi_lvl;
        end else begin
          pend_d.odd = sdi_lvl;
        end
        sdi_cnt_d = sdi_cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q   <= '0;
      sent_q    <= '0;
      sdi_cnt_q <= '0;
      pend_q    <= CFG_RESET;
    end else begin
      shreg_q   <= shreg_d;
      sent_q    <= sent_d;
      sdi_cnt_q <= sdi_cnt_d;
      pend_q    <= pend_d;
    end
  end

  assign sdo      = shreg_q[DATA_W-1];
  assign pend_cfg = pend_q;

  a_r4_msb_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (sdo == $past(load_data[DATA_W-1])));

  a_r5_zero_tail: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_en && (sent_q == SENT_MAX)) |-> (sdo == 1'b0));

  a_r6_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_en && !load && (sdi_cnt_q == SDI_MAX)) |=> $stable(pend_q));

endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port
  import adc_serial_port_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int CONV_CYCLES = 400,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_i,
  input  logic              sck_i,
  input  logic              sdi_i,
  input  logic [DATA_W-1:0] sample_data_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic              busy_o,
  output logic              sleep_o,
  output logic              err_o,
  output logic [1:0]        mux_cfg_o
);

  localparam int NUM_IN = 3;
  localparam logic [NUM_IN-1:0] IN_RST = 3'b001;

  logic [NUM_IN-1:0] raw_in, lvl, rise, fall;

  assign raw_in = {sdi_i, sck_i, conv_i};

  for (genvar g = 0; g < NUM_IN; g++) begin : g_sync
    adc_sync_edge #(
      .STAGES  (SYNC_STAGES),
      .RST_VAL (IN_RST[g])
    ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (raw_in[g]),
      .level_o (lvl[g]),
      .rise_o  (rise[g]),
      .fall_o  (fall[g])
    );
  end

  ctrl_state_e       state;
  logic              load;
  logic [DATA_W-1:0] load_data;
  mux_cfg_t          applied_cfg, pend_cfg;
  logic              sdo_raw;
  logic              xfer_en;

  adc_conv_ctrl #(
    .DATA_W      (DATA_W),
    .CONV_CYCLES (CONV_CYCLES)
  ) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .conv_lvl      (lvl[0]),
    .conv_rise     (rise[0]),
    .conv_fall     (fall[0]),
    .sample_data_i (sample_data_i),
    .pend_cfg      (pend_cfg),
    .state_o       (state),
    .load_o        (load),
    .load_data_o   (load_data),
    .applied_cfg_o (applied_cfg),
    .err_o         (err_o)
  );

  assign xfer_en = (state == ST_XFER);

  adc_shift_port #(
    .DATA_W (DATA_W)
  ) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .load_data (load_data),
    .xfer_en   (xfer_en),
    .sck_rise  (rise[1]),
    .sck_fall  (fall[1]),
    .sdi_lvl   (lvl[2]),
    .sdo       (sdo_raw),
    .pend_cfg  (pend_cfg)
  );

  assign sdo_oe_o  = xfer_en;
  assign sdo_o     = sdo_raw & xfer_en;
  assign busy_o    = (state == ST_CONVERT);
  assign sleep_o   = (state == ST_SLEEP);
  assign mux_cfg_o = applied_cfg;

  a_r3_hiz_when_high: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl[0] && !fall[0] && !$past(fall[0])) |=> !sdo_oe_o);

endmodule

// File: tb/adc_serial_port_bench.sv
module adc_serial_port_bench;

  localparam int DW  = 12;
  localparam int CYC = 40;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          conv_i, sck_i, sdi_i;
  logic [DW-1:0] sample_data_i;
  logic          sdo_o, sdo_oe_o, busy_o, sleep_o, err_o;
  logic [1:0]    mux_cfg_o;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  adc_serial_port #(
    .DATA_W      (DW),
    .CONV_CYCLES (CYC)
  ) u_adc_serial_port (
    .clk           (clk),
    .rst_n         (rst_n),
    .conv_i        (conv_i),
    .sck_i         (sck_i),
    .sdi_i         (sdi_i),
    .sample_data_i (sample_data_i),
    .sdo_o         (sdo_o),
    .sdo_oe_o      (sdo_oe_o),
    .busy_o        (busy_o),
    .sleep_o       (sleep_o),
    .err_o         (err_o),
    .mux_cfg_o     (mux_cfg_o)
  );

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // scoreboard: expected serial bits pushed by the driver, popped by the monitor
  bit   exp_q[$];
  event sample_ev;

  initial begin
    forever begin
      @(sample_ev);
      if (exp_q.size() == 0) begin
        check("R4 scoreboard underflow", 1, 0);
      end else begin
        bit e;
        e = exp_q.pop_front();
        check("R4/R5 sdo_oe", int'(sdo_oe_o), 1);
        check("R4/R5 sdo bit", int'(sdo_o), int'(e));
      end
    end
  end

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // conversion start; returns busy length and applied pairing
  task automatic start_conv(input logic [DW-1:0] data, output int len,
                            output logic [1:0] cfg);
    sample_data_i = data;
    conv_i = 1'b1;
    len = 0;
    cfg = 2'bxx;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (busy_o) break;
    end
    cfg = mux_cfg_o;
    while (busy_o && len < 100000) begin
      len++;
      @(negedge clk);
    end
  endtask

  // transfer: push expected stream, drive sck/sdi, trigger monitor
  task automatic run_xfer(input logic [DW-1:0] word, input logic [15:0] pat,
                          input int nclk);
    conv_i = 1'b0;
    for (int k = 0; k <= nclk; k++) begin
      exp_q.push_back((k < DW) ? word[DW-1-k] : 1'b0);
    end
    settle(6);
    -> sample_ev;
    for (int i = 0; i < nclk; i++) begin
      sdi_i = pat[i];
      repeat (3) @(posedge clk);
      sck_i = 1'b1;
      repeat (4) @(posedge clk);
      sck_i = 1'b0;
      settle(5);
      -> sample_ev;
    end
    settle(1);
  endtask

  initial begin
    int len;
    logic [1:0] cfg;
    rst_n = 1'b0;
    conv_i = 1'b1;
    sck_i = 1'b0;
    sdi_i = 1'b0;
    sample_data_i = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R1 sleep", int'(sleep_o), 1);
    check("R1 oe", int'(sdo_oe_o), 0);
    check("R1 err", int'(err_o), 0);
    check("R1 mux", int'(mux_cfg_o), 2);

    // bring conv low once so that a rising edge can follow
    conv_i = 1'b0;
    settle(6);
    check("R4 oe after fall", int'(sdo_oe_o), 1);
    check("R3 sleep left", int'(sleep_o), 0);

    // conversion 1, default pairing
    start_conv(12'hA5C, len, cfg);
    check("R2 busy length", len, CYC);
    check("R7 default pairing", int'(cfg), 2);
    settle(2);
    check("R3 sleep after done", int'(sleep_o), 1);
    check("R3 hi-z while high", int'(sdo_oe_o), 0);
    // sdi: 0,1 captured; later ones ignored
    run_xfer(12'hA5C, 16'b1111_1111_1111_1110, 14);

    // conversion 2 uses word 01 (CH1+, CH0-)
    start_conv(12'h3F1, len, cfg);
    check("R7 next pairing 01", int'(cfg), 1);
    check("R6 late bits ignored", int'(cfg), 1);
    check("R2 busy length 2", len, CYC);
    run_xfer(12'h3F1, 16'b0000_0000_0000_0011, 16);

    // conversion 3 uses word 11
    start_conv(12'hFFF, len, cfg);
    check("R7 pairing 11", int'(cfg), 3);
    run_xfer(12'hFFF, 16'b1111_1111_1111_1100, 13);

    // early release: error, previous result
    sample_data_i = 12'h123;
    conv_i = 1'b1;
    repeat (12) @(posedge clk);
    check("R7 pairing 00", int'(mux_cfg_o), 0);
    check("R8 no err yet", int'(err_o), 0);
    conv_i = 1'b0;
    settle(6);
    check("R8 err set", int'(err_o), 1);
    check("R8 not busy", int'(busy_o), 0);
    run_xfer(12'hFFF, 16'b0000_0000_0000_0001, 12);

    // next start clears error
    start_conv(12'h001, len, cfg);
    check("R8 err cleared", int'(err_o), 0);
    check("R7 pairing 10", int'(cfg), 2);
    run_xfer(12'h001, 16'h0000, 14);
    check("R6 scoreboard drained", exp_q.size(), 0);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule